// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block sits beside the CPU core of a small 8-bit microcontroller. It decides when the core and its peripherals receive clock enables, and it turns a raw reset pin into a clean synchronous system reset. A reset is taken only after the pin has stayed high for a full qualification window. Software selects one of two low-power states by writing a control byte.

In the light-sleep state only the CPU clock enable is dropped, so timers, the serial unit and interrupt logic keep working. Any enabled interrupt request wakes the core and raises a one-cycle wake pulse, so the core resumes at the matching service entry. In the deep-sleep state the oscillator enable is dropped as well, and only a qualified reset brings the chip back.

While either state is active, the block also supplies override levels for the two external memory strobes and for the ports. A control write takes effect on the first machine-cycle boundary after the write, where a machine cycle is a fixed number of oscillator clocks.

Top module: `pwr_mode_ctl`

## Requirements
- R1: `sys_rst` rises only after `rst_pin` has been sampled high on QUAL_CYC (default 24) consecutive rising clock edges. It appears two edges after the last of those samples and stays high while the pin stays high. It falls two edges after the pin is first sampled low, so a shorter pulse has no effect.
- R2: The control byte `ctl_q` uses this layout: bit 0 requests light sleep, bit 1 requests deep sleep, bits 2 and 3 are general-purpose flags, and bits 7:6 are stored as written. Bits 5:4 always read 0. `por` or `sys_rst` clears the whole byte to 0x00. A write is accepted only while running, so writes made during either sleep state are ignored.
- R3: While in light sleep, `cpu_clk_en` is 0 while `per_clk_en` and `osc_run` stay 1. The state persists for as long as `irq_req` is all zero.
- R4: A sleep request takes effect only at a machine-cycle boundary. These boundaries are the rising edges numbered 12k (MC_LEN = 12) counted from the first edge with `por` low. A request is never acted on at the same edge that writes it.
- R5: In deep sleep, `cpu_clk_en`, `per_clk_en` and `osc_run` are all 0, and interrupt requests have no effect.
- R6: In light sleep, any nonzero `irq_req` returns the block to running on the next edge. The same edge clears bit 0 of `ctl_q`, keeps the other bits, and raises `idle_wake` for exactly one cycle.
- R7: If bits 0 and 1 are both set at the boundary, the block enters deep sleep.
- R8: `strobe_hold` is 1 in either sleep state and 0 while running. `strobe_level` is 1 in light sleep and 0 in deep sleep.
- R9: `p0_float` is 1 when a sleep state is active and `ext_code` is 1. `p2_force_data` is 1 only in deep sleep, so in light sleep port 2 keeps its address drive.
- R10: A qualified reset returns the block from either sleep state to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator-rate clock |
| por | input | 1 | Power-on initialisation, synchronous, active high |
| rst_pin | input | 1 | Raw external reset pin, asynchronous |
| ctl_we | input | 1 | One-cycle write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| irq_req | input | NIRQ | Enabled interrupt requests |
| ext_code | input | 1 | Code is fetched from external program memory |
| sys_rst | output | 1 | Qualified synchronous system reset |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| ctl_q | output | 8 | Current control byte |
| strobe_hold | output | 1 | Memory strobes are overridden |
| strobe_level | output | 1 | Override level for the memory strobes |
| p0_float | output | 1 | Port 0 pins released to high impedance |
| p2_force_data | output | 1 | Port 2 forced to drive its data latch |
| idle_wake | output | 1 | One-cycle pulse when light sleep ends on an interrupt |

## Verification
Assertions check the following on every cycle:
- `sys_rst` drops once the synchronised pin is low.
- A cleared state follows every reset.
- Light sleep holds while no request is present.
- State changes out of running happen only on a boundary.
- Deep sleep persists while interrupts are active.
- The combined request resolves to deep sleep.
- An interrupt exit clears the request bit and pulses the wake output.
- The strobe override level agrees with the peripheral enable.

Only the bench scenarios can show the following:
- The exact 24-edge qualification window, including a rejected short pulse.
- The two-edge release latency.
- That writes made during sleep leave the control byte unchanged.
- The port override outputs with and without external code.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2
  } pm_state_t;

  localparam int PM_IDL_BIT = 0;
  localparam int PM_PD_BIT  = 1;
  localparam logic [7:0] PM_CTL_MASK = 8'hCF;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int QUAL_CYC = 24
) (
  input  logic clk,
  input  logic por,
  input  logic pin,
  output logic rst_o
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(QUAL_CYC - 1);

  logic          sync1, sync2;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (por) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      hi_cnt <= '0;
      rst_o  <= 1'b0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
      if (!sync2)
        hi_cnt <= '0;
      else if (hi_cnt != CNT_TOP)
        hi_cnt <= hi_cnt + 1'b1;
      rst_o <= sync2 && (hi_cnt == CNT_TOP);
    end
  end

  // R1: a low synchronised pin always releases reset on the next edge
  p_release_r1: assert property (@(posedge clk) disable iff (por)
    !sync2 |=> !rst_o);
endmodule

// File: rtl/pmc_mc_tick.sv
module pmc_mc_tick #(
  parameter int MC_LEN = 12
) (
  input  logic clk,
  input  logic por,
  output logic bnd
);
  localparam int PW = $clog2(MC_LEN);
  localparam logic [PW-1:0] PH_LAST = PW'(MC_LEN - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (por)
      phase <= '0;
    else if (phase == PH_LAST)
      phase <= '0;
    else
      phase <= phase + 1'b1;
  end

  assign bnd = (phase == PH_LAST);

  // R4: boundaries are never adjacent
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (por)
    bnd |=> !bnd);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            por,
  input  logic            sys_rst,
  input  logic            bnd,
  input  logic            we,
  input  logic [7:0]      wdata,
  input  logic [NIRQ-1:0] irq,
  output pm_state_t       st,
  output logic [7:0]      ctl,
  output logic            wake
);
  always_ff @(posedge clk) begin
    if (por || sys_rst) begin
      st   <= PM_RUN;
      ctl  <= 8'h00;
      wake <= 1'b0;
    end else begin
      wake <= 1'b0;
      unique case (st)
        PM_RUN: begin
          if (bnd) begin
            if (ctl[PM_PD_BIT])
              st <= PM_PDOWN;
            else if (ctl[PM_IDL_BIT])
              st <= PM_IDLE;
          end
          if (we)
            ctl <= wdata & PM_CTL_MASK;
        end
        PM_IDLE: begin
          if (|irq) begin
            st              <= PM_RUN;
            ctl[PM_IDL_BIT] <= 1'b0;
            wake            <= 1'b1;
          end
        end
        default: st <= st;
      endcase
    end
  end

  // R2: every reset leaves a cleared byte and the running state
  p_rst_clears_r2: assert property (@(posedge clk) disable iff (por)
    $past(sys_rst) |-> (ctl == 8'h00) && (st == PM_RUN));
  // R3: light sleep persists without a request
  p_idle_wait_r3: assert property (@(posedge clk) disable iff (por || sys_rst)
    (st == PM_IDLE) && (irq == '0) |=> (st == PM_IDLE));
  // R4: leaving the running state happens only on a boundary
  p_entry_bnd_r4: assert property (@(posedge clk) disable iff (por || sys_rst)
    (st != PM_RUN) && $past(st == PM_RUN) |-> $past(bnd));
  // R5: deep sleep ignores interrupts
  p_pd_sticky_r5: assert property (@(posedge clk) disable iff (por || sys_rst)
    (st == PM_PDOWN) |=> (st == PM_PDOWN));
  // R6: an interrupt exit clears the request bit and pulses wake
  p_idle_exit_r6: assert property (@(posedge clk) disable iff (por || sys_rst)
    (st == PM_RUN) && $past(st == PM_IDLE && !sys_rst) |-> !ctl[PM_IDL_BIT] && wake);
  // R7: the deep-sleep request wins at a boundary
  p_pd_wins_r7: assert property (@(posedge clk) disable iff (por || sys_rst)
    $past(st == PM_RUN && bnd && ctl[PM_PD_BIT] && !sys_rst) |-> (st == PM_PDOWN));
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pmc_pkg::*;
#(
  parameter int NIRQ     = 4,
  parameter int QUAL_CYC = 24,
  parameter int MC_LEN   = 12
) (
  input  logic            clk,
  input  logic            por,
  input  logic            rst_pin,
  input  logic            ctl_we,
  input  logic [7:0]      ctl_wdata,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            ext_code,
  output logic            sys_rst,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            osc_run,
  output logic [7:0]      ctl_q,
  output logic            strobe_hold,
  output logic            strobe_level,
  output logic            p0_float,
  output logic            p2_force_data,
  output logic            idle_wake
);
  logic      mc_bnd;
  pm_state_t st;

  pmc_rst_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk   (clk),
    .por   (por),
    .pin   (rst_pin),
    .rst_o (sys_rst)
  );

  pmc_mc_tick #(.MC_LEN(MC_LEN)) u_tick (
    .clk (clk),
    .por (por),
    .bnd (mc_bnd)
  );

  pmc_mode_fsm #(.NIRQ(NIRQ)) u_fsm (
    .clk     (clk),
    .por     (por),
    .sys_rst (sys_rst),
    .bnd     (mc_bnd),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .irq     (irq_req),
    .st      (st),
    .ctl     (ctl_q),
    .wake    (idle_wake)
  );

  assign cpu_clk_en    = (st == PM_RUN);
  assign per_clk_en    = (st != PM_PDOWN);
  assign osc_run       = (st != PM_PDOWN);
  assign strobe_hold   = (st != PM_RUN);
  assign strobe_level  = (st == PM_IDLE);
  assign p0_float      = (st != PM_RUN) && ext_code;
  assign p2_force_data = (st == PM_PDOWN);

  // R8: while strobes are overridden, their level tracks the peripheral enable
  p_strobe_r8: assert property (@(posedge clk) disable iff (por)
    strobe_hold |-> (strobe_level == per_clk_en));
endmodule

// File: tb/sim_pwr_mode_ctl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctl;
  localparam int NIRQ = 4;
  localparam int QUAL = 24;
  localparam int MCL  = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            por = 1'b1, rst_pin = 1'b0, ctl_we = 1'b0, ext_code = 1'b0;
  logic [7:0]      ctl_wdata = 8'h00;
  logic [NIRQ-1:0] irq_req = '0;
  logic sys_rst, cpu_clk_en, per_clk_en, osc_run, strobe_hold, strobe_level;
  logic p0_float, p2_force_data, idle_wake;
  logic [7:0] ctl_q;

  pwr_mode_ctl #(.NIRQ(NIRQ), .QUAL_CYC(QUAL), .MC_LEN(MCL)) u0 (
    .clk(clk), .por(por), .rst_pin(rst_pin), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .irq_req(irq_req), .ext_code(ext_code), .sys_rst(sys_rst), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_run(osc_run), .ctl_q(ctl_q), .strobe_hold(strobe_hold),
    .strobe_level(strobe_level), .p0_float(p0_float), .p2_force_data(p2_force_data),
    .idle_wake(idle_wake));

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: mode 0 run, 1 light sleep, 2 deep sleep
  int run0 = 0, run1 = 0, run2 = 0, mph = 0, mmode = 0;
  bit m_rst = 0, mwake = 0;
  logic [7:0] mctl = 8'h00;

  always @(posedge clk) begin
    if (por) begin
      run0 = 0; run1 = 0; run2 = 0; m_rst = 0; mph = 0; mmode = 0; mctl = 8'h00; mwake = 0;
    end else begin
      if (m_rst) begin
        mmode = 0; mctl = 8'h00; mwake = 0;
      end else begin
        mwake = 0;
        if (mmode == 0) begin
          if (mph == MCL - 1) begin
            if (mctl[1]) mmode = 2;
            else if (mctl[0]) mmode = 1;
          end
          if (ctl_we) mctl = ctl_wdata & 8'hCF;
        end else if (mmode == 1 && irq_req != '0) begin
          mmode = 0; mctl[0] = 1'b0; mwake = 1;
        end
      end
      mph  = (mph + 1) % MCL;
      run2 = run1;
      run1 = run0;
      run0 = rst_pin ? run1 + 1 : 0;
      m_rst = (run2 >= QUAL);
    end
  end

  always @(negedge clk) begin
    if (!por && !finished) begin
      chk("R1", "sys_rst", {7'd0, sys_rst}, {7'd0, m_rst});
      chk("R3", "cpu_clk_en", {7'd0, cpu_clk_en}, {7'd0, mmode == 0});
      chk("R5", "per_clk_en", {7'd0, per_clk_en}, {7'd0, mmode != 2});
      chk("R5", "osc_run", {7'd0, osc_run}, {7'd0, mmode != 2});
      chk("R2", "ctl_q", ctl_q, mctl);
      chk("R6", "idle_wake", {7'd0, idle_wake}, {7'd0, mwake});
      chk("R8", "strobe_hold", {7'd0, strobe_hold}, {7'd0, mmode != 0});
      chk("R8", "strobe_level", {7'd0, strobe_level}, {7'd0, mmode == 1});
      chk("R9", "p0_float", {7'd0, p0_float}, {7'd0, (mmode != 0) && ext_code});
      chk("R9", "p2_force_data", {7'd0, p2_force_data}, {7'd0, mmode == 2});
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    tick(1);
    ctl_we = 1'b0;
  endtask

  task automatic wait_phase(input int p);
    while (mph != p) tick(1);
  endtask

  task automatic pin_pulse(input int n);
    rst_pin = 1'b1; tick(n); rst_pin = 1'b0;
  endtask

  task automatic finish_run;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    tick(5);
    por = 1'b0;
    tick(1);
    chk("R2", "reset ctl_q", ctl_q, 8'h00);
    chk("R10", "reset cpu_clk_en", {7'd0, cpu_clk_en}, 8'd1);

    wr(8'hFC);
    tick(1);
    chk("R2", "masked write", ctl_q, 8'hCC);

    pin_pulse(QUAL - 4);
    tick(6);
    chk("R1", "short pulse sys_rst", {7'd0, sys_rst}, 8'd0);
    chk("R1", "short pulse keeps ctl", ctl_q, 8'hCC);

    wait_phase(2);
    wr(8'hCD);
    tick(3);
    chk("R4", "no entry before boundary", {7'd0, cpu_clk_en}, 8'd1);
    tick(MCL);
    chk("R3", "idle cpu off", {7'd0, cpu_clk_en}, 8'd0);
    chk("R3", "idle periph on", {7'd0, per_clk_en}, 8'd1);
    ext_code = 1'b1;
    tick(2);
    chk("R9", "idle p0 float", {7'd0, p0_float}, 8'd1);
    chk("R9", "idle p2 address kept", {7'd0, p2_force_data}, 8'd0);
    chk("R8", "idle strobe high", {7'd0, strobe_level}, 8'd1);
    wr(8'h02);
    tick(MCL + 2);
    chk("R2", "write in idle ignored", ctl_q, 8'hCD);
    irq_req = 4'b0100;
    tick(1);
    irq_req = '0;
    chk("R6", "wake pulse", {7'd0, idle_wake}, 8'd1);
    tick(1);
    chk("R6", "idle exit", {7'd0, cpu_clk_en}, 8'd1);
    chk("R6", "idle bit cleared", ctl_q, 8'hCC);

    wr(8'h0E);
    tick(MCL + 2);
    chk("R5", "pd osc off", {7'd0, osc_run}, 8'd0);
    chk("R8", "pd strobe low", {7'd0, strobe_level}, 8'd0);
    chk("R9", "pd p2 data", {7'd0, p2_force_data}, 8'd1);
    irq_req = 4'b1111;
    tick(6);
    irq_req = '0;
    chk("R5", "pd ignores irq", {7'd0, osc_run}, 8'd0);
    ext_code = 1'b0;

    pin_pulse(QUAL + 6);
    chk("R1", "qualified reset", {7'd0, sys_rst}, 8'd1);
    tick(4);
    chk("R10", "pd exit by reset", {7'd0, cpu_clk_en}, 8'd1);
    chk("R10", "ctl cleared", ctl_q, 8'h00);

    wr(8'h03);
    tick(MCL + 2);
    chk("R7", "both bits -> pd", {7'd0, osc_run}, 8'd0);
    chk("R7", "both bits kept", ctl_q, 8'h03);
    pin_pulse(QUAL + 3);
    tick(4);
    chk("R10", "release after pd", {7'd0, osc_run}, 8'd1);

    wr(8'h01);
    tick(MCL + 2);
    chk("R3", "idle again", {7'd0, cpu_clk_en}, 8'd0);
    pin_pulse(QUAL + 3);
    tick(4);
    chk("R10", "idle exit by reset", {7'd0, cpu_clk_en}, 8'd1);
    chk("R10", "idle exit no wake", {7'd0, idle_wake}, 8'd0);

    tick(3);
    finish_run();
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule